// File: doc/BRIEF.md
# Pause Quantum Countdown and Transmit Gate

This block keeps the pause time of a full-duplex Ethernet MAC. When the receive path recognises a valid pause frame, it sends a one-cycle load strobe together with the 16-bit pause value from that frame. In full-duplex mode the block takes that value. It then counts the value down in pause quanta, where one quantum is 512 bit times, or 128 receive clocks when the interface moves a nibble per clock. While receive pause is enabled and time remains, the block holds the transmitter so that no new frame starts.

Whether the countdown waits for the transmitter depends on the receive-pause enable. With the enable set, the count runs only while the transmitter reports that it has stopped. With the enable clear, the count runs all the time and nothing is held. A retry-test mode shortens each quantum to one clock so that the count can be exercised quickly. When a decrement brings the count to zero, the block raises a masked, one-cycle expiry interrupt request.

Top module: `pause_gate`

## Requirements
- R1: With `full_duplex` high, a cycle with `load_strobe` high replaces `pause_time` with `load_value` at the next clock edge. This happens whatever the previous value was and whatever the state of `rx_pause_en`.
- R2: With `full_duplex` low, `load_strobe` has no effect on `pause_time`, and `tx_hold` stays low.
- R3: `tx_hold` is high exactly when `rx_pause_en` and `full_duplex` are both high and `pause_time` is non-zero.
- R4: With `retry_test` low, `pause_time` drops by one after every QUANTUM_CLKS (default 128) counting clocks. The first decrement comes at the 128th clock edge after the load edge.
- R5: With `retry_test` high, `pause_time` drops by one on every counting clock.
- R6: With `rx_pause_en` high, counting takes place only in cycles where `tx_stopped` is high, and the value otherwise holds.
- R7: With `rx_pause_en` low, counting takes place whether or not `tx_stopped` is high.
- R8: `pause_time` stops at zero and never wraps.
- R9: When a decrement brings `pause_time` from 1 to 0 and `irq_mask` is high, `expire_irq` is high for exactly the following cycle. With `irq_mask` low, `expire_irq` does not rise.
- R10: Every load restarts the quantum prescaler from zero, so the first decrement after a load always waits a full quantum.
- R11: Loading zero drops `tx_hold` at the next edge and raises no `expire_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one nibble per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | High when the MAC runs full duplex |
| rx_pause_en | input | 1 | Honour received pause frames |
| retry_test | input | 1 | Test mode: one clock per quantum |
| tx_stopped | input | 1 | Transmitter idle indication |
| irq_mask | input | 1 | Enables the expiry interrupt request |
| load_strobe | input | 1 | Valid pause frame received, one cycle |
| load_value | input | 16 | Pause time carried by the frame |
| tx_hold | output | 1 | Blocks the start of a new frame |
| expire_irq | output | 1 | One-cycle pulse on count reaching zero |
| pause_time | output | 16 | Current pause time |

## Verification
The hardest case to reach from the ports is the interaction between the prescaler phase and a reload part-way through a quantum. To expose a prescaler that was not restarted, the count must be left half-finished in normal mode and then reloaded. The bench waits 64 clocks after a first load, reloads, and then samples one clock before and one clock after the expected first decrement. The remaining vectors use retry-test mode, so that zero clamping, the expiry pulse and the effect of the enable on counting can each be reached in a few cycles.

// File: rtl/pause_gate.sv
module pause_gate #(
  parameter int WIDTH        = 16,
  parameter int QUANTUM_CLKS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_duplex,
  input  logic             rx_pause_en,
  input  logic             retry_test,
  input  logic             tx_stopped,
  input  logic             irq_mask,
  input  logic             load_strobe,
  input  logic [WIDTH-1:0] load_value,
  output logic             tx_hold,
  output logic             expire_irq,
  output logic [WIDTH-1:0] pause_time
);

  localparam int PW = (QUANTUM_CLKS > 2) ? $clog2(QUANTUM_CLKS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(QUANTUM_CLKS - 1);

  logic [WIDTH-1:0] pause_q;
  logic [PW-1:0]    pre_q;
  logic             irq_q;

  logic load_now, run, nonzero, pre_last, step;

  assign load_now = load_strobe & full_duplex;
  assign run      = rx_pause_en ? tx_stopped : 1'b1;
  assign nonzero  = |pause_q;
  assign pre_last = (pre_q == PRE_LAST);
  assign step     = run & nonzero & (retry_test | pre_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_q <= '0;
      pre_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (load_now) begin
        pause_q <= load_value;
        pre_q   <= '0;
      end else begin
        if (run && nonzero && !retry_test)
          pre_q <= pre_last ? '0 : pre_q + 1'b1;
        if (step) begin
          pause_q <= pause_q - 1'b1;
          irq_q   <= irq_mask && (pause_q == WIDTH'(1));
        end
      end
    end
  end

  assign tx_hold    = rx_pause_en & full_duplex & nonzero;
  assign expire_irq = irq_q;
  assign pause_time = pause_q;

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_strobe && full_duplex) |=> (pause_time == $past(load_value)));

  p_halfdup_noload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !full_duplex |=> (pause_time <= $past(pause_time)));

  p_wait_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pause_en && !tx_stopped && !(load_strobe && full_duplex)) |=> $stable(pause_time));

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_strobe && full_duplex) |=>
      (pause_time == $past(pause_time) || pause_time == $past(pause_time) - 1'b1));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_time == '0 && !(load_strobe && full_duplex)) |=> (pause_time == '0));

  p_irq_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire_irq |-> (pause_time == '0));

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |=> !expire_irq);

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire_irq |=> !expire_irq);

endmodule

// File: tb/tb_pause_gate.sv
module tb_pause_gate;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic full_duplex = 1'b0, rx_pause_en = 1'b0, retry_test = 1'b0;
  logic tx_stopped = 1'b0, irq_mask = 1'b0, load_strobe = 1'b0;
  logic [15:0] load_value = '0;
  logic tx_hold, expire_irq;
  logic [15:0] pause_time;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pause_gate dut (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .rx_pause_en(rx_pause_en),
    .retry_test(retry_test), .tx_stopped(tx_stopped), .irq_mask(irq_mask),
    .load_strobe(load_strobe), .load_value(load_value),
    .tx_hold(tx_hold), .expire_irq(expire_irq), .pause_time(pause_time)
  );

  // fd, en, rt, stop, load, value[16], cycles[8], exp_value[16], exp_hold
  localparam int NV = 8;
  localparam logic [45:0] VEC [NV] = '{
    {1'b1,1'b1,1'b1,1'b0,1'b1,16'h0005,8'd3, 16'h0005,1'b1},  // R6 R3
    {1'b1,1'b1,1'b1,1'b1,1'b0,16'h0000,8'd2, 16'h0003,1'b1},  // R5
    {1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,8'd1, 16'h0002,1'b0},  // R7 R3
    {1'b0,1'b1,1'b1,1'b0,1'b1,16'h0009,8'd0, 16'h0002,1'b0},  // R2
    {1'b1,1'b1,1'b1,1'b1,1'b1,16'h1234,8'd0, 16'h1234,1'b1},  // R1
    {1'b1,1'b0,1'b1,1'b1,1'b1,16'h0007,8'd0, 16'h0007,1'b0},  // R1
    {1'b1,1'b1,1'b1,1'b1,1'b0,16'h0000,8'd10,16'h0000,1'b0},  // R8
    {1'b1,1'b1,1'b1,1'b1,1'b1,16'hFFFF,8'd1, 16'hFFFE,1'b1}   // R1 R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] v);
    load_value  = v;
    load_strobe = 1'b1;
    @(negedge clk);
    load_strobe = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int irq_seen;
    repeat (3) @(negedge clk);
    check("R3 reset pause_time", 32'(pause_time), 32'h0);
    check("R3 reset hold", 32'(tx_hold), 32'h0);
    check("R9 reset irq", 32'(expire_irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {full_duplex, rx_pause_en, retry_test, tx_stopped} = VEC[i][45:42];
      if (VEC[i][41]) do_load(VEC[i][40:25]);
      repeat (int'(VEC[i][24:17])) @(negedge clk);
      check($sformatf("R1-group vector %0d value", i), 32'(pause_time), 32'(VEC[i][16:1]));
      check($sformatf("R3 vector %0d hold", i), 32'(tx_hold), 32'(VEC[i][0]));
    end

    // R4: a normal quantum takes 128 clocks
    full_duplex = 1; rx_pause_en = 1; retry_test = 0; tx_stopped = 1; irq_mask = 0;
    do_load(16'd2);
    repeat (127) @(negedge clk);
    check("R4 before quantum end", 32'(pause_time), 32'd2);
    @(negedge clk);
    check("R4 at quantum end", 32'(pause_time), 32'd1);

    // R10: a reload part-way through a quantum restarts the prescaler
    do_load(16'd3);
    repeat (64) @(negedge clk);
    do_load(16'd3);
    repeat (127) @(negedge clk);
    check("R10 no early decrement", 32'(pause_time), 32'd3);
    @(negedge clk);
    check("R10 decrement after full quantum", 32'(pause_time), 32'd2);

    // R9: expiry pulse when the mask is set
    retry_test = 1; irq_mask = 1;
    do_load(16'd1);
    check("R9 irq not yet", 32'(expire_irq), 32'd0);
    @(negedge clk);
    check("R9 irq pulse", 32'(expire_irq), 32'd1);
    check("R8 value zero", 32'(pause_time), 32'd0);
    @(negedge clk);
    check("R9 irq one cycle", 32'(expire_irq), 32'd0);

    // R9: the mask blocks the pulse
    irq_mask = 0;
    do_load(16'd1);
    irq_seen = 0;
    repeat (4) begin @(negedge clk); if (expire_irq) irq_seen++; end
    check("R9 masked no irq", 32'(irq_seen), 32'd0);

    // R11: loading zero releases the hold with no pulse
    irq_mask = 1; tx_stopped = 0;
    do_load(16'd5);
    check("R11 hold before zero load", 32'(tx_hold), 32'd1);
    do_load(16'd0);
    check("R11 hold released", 32'(tx_hold), 32'd0);
    irq_seen = 0;
    repeat (5) begin @(negedge clk); if (expire_irq) irq_seen++; end
    check("R11 no irq on zero load", 32'(irq_seen), 32'd0);

    // R2: a half-duplex load is ignored
    full_duplex = 0; tx_stopped = 0;
    do_load(16'h00AA);
    check("R2 half duplex no load", 32'(pause_time), 32'd0);
    check("R2 half duplex no hold", 32'(tx_hold), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule